// File: doc/BRIEF.md
# Telephony Master-Clock Divider Selector

This block runs directly on a telephony master clock of 1.536, 1.544 or 2.048 MHz. From it, the block produces two single-cycle clock-enable pulses. The first is a 256 kHz enable that paces the switched-capacitor filter logic. The second is an 8 kHz frame strobe. The divide ratio comes from a select level read off the receive bit-clock pin.

The same pin also tells the block which timing mode is in use. A pin that holds one level marks synchronous mode, where a single bit clock serves both directions. A pin that keeps toggling marks separate receive timing, and its levels are then not taken as a select. A new select value only takes hold at a frame boundary.

When a transmit frame sync is present, the frame strobe locks onto it. In the 1.544 MHz case a frame holds 193 master clocks. A locked frame therefore waits up to one extra clock at its end for the sync, which absorbs the surplus pulse and keeps frames at 8 kHz.

Top module: `mcd_clk_divsel`

## Requirements
- R1: While reset is asserted, `filt_ce_o`, `frame_ce_o` and `sync_mode_o` are 0 and `sel_fast_o` is 1, so the divider starts in the 2.048 MHz setting.
- R2: With `sel_fast_o` = 1 and no frame sync, `filt_ce_o` pulses every 8 clocks and `frame_ce_o` pulses every 256 clocks.
- R3: With `sel_fast_o` = 0 and no frame sync, `filt_ce_o` pulses every 6 clocks and `frame_ce_o` pulses every 192 clocks.
- R4: Each frame carries exactly 32 filter enables, and `frame_ce_o` is high only in the same cycle as the 32nd of them.
- R5: `sync_mode_o` goes to 0 within 5 clocks of any level change on `bclkr_pin_i`. It stays 0 for at least 30 clocks after that change. It returns to 1 within 100 clocks once the pin holds steady.
- R6: The pin level is captured as the next select only while the pin is static (1 = 2.048 MHz, 0 = 1.536/1.544 MHz). A toggling pin leaves `sel_fast_o` unchanged.
- R7: `sel_fast_o` changes only in a cycle where `frame_ce_o` is 1.
- R8: One clock after a rising edge of `fsx_i`, both `frame_ce_o` and `filt_ce_o` are 1. The filter and frame counts restart from that point.
- R9: When a frame is locked to `fsx_i` and its count completes with no sync, the end of the frame is held one clock for the sync. A 193-clock sync period then gives 193-clock frames of 32 enables, with one enable interval of 7 and the rest 6.
- R10: If no sync arrives during that one-clock hold, the frame strobe still fires after the hold and the lock drops. Following frames run at the nominal length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock (1.536, 1.544 or 2.048 MHz) |
| rst_ni | input | 1 | Active-low reset, synchronous to `clk_i` |
| bclkr_pin_i | input | 1 | Receive bit-clock pin; asynchronous, used for select and mode detection |
| fsx_i | input | 1 | Transmit frame sync, synchronous to `clk_i` |
| filt_ce_o | output | 1 | 256 kHz filter clock-enable pulse |
| frame_ce_o | output | 1 | 8 kHz frame strobe |
| sync_mode_o | output | 1 | 1 when the receive bit-clock pin is static (synchronous mode) |
| sel_fast_o | output | 1 | Divider select in force: 1 = 2.048 MHz, 0 = 1.536/1.544 MHz |

## Verification
The properties assume that `fsx_i` is synchronous to the master clock, and that a sync edge never sits closer than one clock to the previous filter enable unless it realigns the frame. The enable-gap bound also assumes that sync edges do not come faster than a frame. The stimulus drives every input just after a falling clock edge. It sends sync pulses one clock wide, at fixed periods of 192, 193 or 256 clocks, and starts each train with a single mid-frame edge. The receive pin is either held for well over the static window or toggled every 3 clocks, so the static detector is always clearly on one side of its threshold.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   typedef enum logic [0:0] {
      SEQ_RUN  = 1'b0,
      SEQ_HOLD = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic filt;
      logic frame;
   } tick_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mcd_pin_monitor.sv
module mcd_pin_monitor #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STATIC_CYC  = 64,
   parameter bit          SEL_RESET   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic static_o,
   output logic level_o
);

   localparam int unsigned CW = $clog2(STATIC_CYC);

   logic [SYNC_STAGES:0] sync_q;
   logic                 pin_s;
   logic                 prev_q;
   logic [CW-1:0]        cnt_q;
   logic                 static_q;
   logic                 level_q;

   assign sync_q[0] = pin_i;

   // synchronizer depth is a parameter; zero stages passes the pin through
   for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i) begin
         if (!rst_ni) sync_q[g] <= 1'b1;
         else         sync_q[g] <= sync_q[g-1];
      end
   end

   assign pin_s = sync_q[SYNC_STAGES];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q   <= 1'b1;
         cnt_q    <= '0;
         static_q <= 1'b0;
         level_q  <= SEL_RESET;
      end else begin
         prev_q <= pin_s;
         if (pin_s != prev_q) begin
            cnt_q    <= '0;
            static_q <= 1'b0;
         end else if (cnt_q == CW'(STATIC_CYC - 1)) begin
            static_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (static_q && (pin_s == prev_q)) level_q <= pin_s;
      end
   end

   assign static_o = static_q;
   assign level_o  = level_q;

endmodule

// File: rtl/mcd_frame_seq.sv
module mcd_frame_seq
   import mcd_pkg::*;
#(
   parameter int unsigned DIV_HI    = 8,
   parameter int unsigned DIV_LO    = 6,
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned HOLD_CYC  = 1,
   parameter bit          SEL_RESET = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sel_next_i,
   input  logic fsx_i,
   output logic filt_ce_o,
   output logic frame_ce_o,
   output logic sel_fast_o
);

   localparam int unsigned DMAX = max2(DIV_HI, DIV_LO);
   localparam int unsigned PW   = $clog2(DMAX);
   localparam int unsigned SW   = $clog2(SLOTS);
   localparam int unsigned HW   = $clog2(HOLD_CYC + 1);

   logic [PW-1:0] pre_q, pre_d, div_m1;
   logic [SW-1:0] slot_q, slot_d;
   logic [HW-1:0] hold_q, hold_d;
   seq_state_e    st_q, st_d;
   logic          lock_q, lock_d;
   logic          sel_q, sel_d;
   logic          fsx_q, fsx_edge;
   logic          tick, restart;
   tick_t         ev, ev_q;

   assign fsx_edge = fsx_i & ~fsx_q;
   assign div_m1   = sel_q ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
   assign tick     = (pre_q == div_m1);

   always_comb begin
      pre_d    = pre_q;
      slot_d   = slot_q;
      hold_d   = hold_q;
      st_d     = st_q;
      lock_d   = lock_q;
      sel_d    = sel_q;
      ev       = '0;
      restart  = 1'b0;
      if (fsx_edge) begin
         restart = 1'b1;
         lock_d  = 1'b1;
      end else if (st_q == SEQ_HOLD) begin
         if (hold_q == HW'(HOLD_CYC - 1)) begin
            restart = 1'b1;
            lock_d  = 1'b0;
         end else begin
            hold_d = hold_q + 1'b1;
         end
      end else if (tick && (slot_q == SW'(SLOTS - 1))) begin
         if (lock_q) begin
            st_d   = SEQ_HOLD;
            hold_d = '0;
         end else begin
            restart = 1'b1;
         end
      end else if (tick) begin
         ev.filt = 1'b1;
         pre_d   = '0;
         slot_d  = slot_q + 1'b1;
      end else begin
         pre_d = pre_q + 1'b1;
      end
      if (restart) begin
         ev.filt  = 1'b1;
         ev.frame = 1'b1;
         pre_d    = '0;
         slot_d   = '0;
         hold_d   = '0;
         st_d     = SEQ_RUN;
         sel_d    = sel_next_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pre_q  <= '0;
         slot_q <= '0;
         hold_q <= '0;
         st_q   <= SEQ_RUN;
         lock_q <= 1'b0;
         sel_q  <= SEL_RESET;
         fsx_q  <= 1'b0;
         ev_q   <= '0;
      end else begin
         pre_q  <= pre_d;
         slot_q <= slot_d;
         hold_q <= hold_d;
         st_q   <= st_d;
         lock_q <= lock_d;
         sel_q  <= sel_d;
         fsx_q  <= fsx_i;
         ev_q   <= ev;
      end
   end

   assign filt_ce_o  = ev_q.filt;
   assign frame_ce_o = ev_q.frame;
   assign sel_fast_o = sel_q;

endmodule

// File: rtl/mcd_clk_divsel.sv
module mcd_clk_divsel #(
   parameter int unsigned DIV_HI      = 8,
   parameter int unsigned DIV_LO      = 6,
   parameter int unsigned SLOTS       = 32,
   parameter int unsigned HOLD_CYC    = 1,
   parameter int unsigned STATIC_CYC  = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SEL_DEFAULT = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bclkr_pin_i,
   input  logic fsx_i,
   output logic filt_ce_o,
   output logic frame_ce_o,
   output logic sync_mode_o,
   output logic sel_fast_o
);

   if (DIV_HI < 2 || DIV_LO < 2) begin : g_bad_div
      $error("divide ratios must be at least 2");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end
   if (STATIC_CYC < 4) begin : g_bad_static
      $error("STATIC_CYC must be at least 4");
   end

   logic sel_next;

   mcd_pin_monitor #(
      .SYNC_STAGES (SYNC_STAGES),
      .STATIC_CYC  (STATIC_CYC),
      .SEL_RESET   (SEL_DEFAULT)
   ) pin_mon_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (bclkr_pin_i),
      .static_o (sync_mode_o),
      .level_o  (sel_next)
   );

   mcd_frame_seq #(
      .DIV_HI    (DIV_HI),
      .DIV_LO    (DIV_LO),
      .SLOTS     (SLOTS),
      .HOLD_CYC  (HOLD_CYC),
      .SEL_RESET (SEL_DEFAULT)
   ) seq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_next_i (sel_next),
      .fsx_i      (fsx_i),
      .filt_ce_o  (filt_ce_o),
      .frame_ce_o (frame_ce_o),
      .sel_fast_o (sel_fast_o)
   );

endmodule

// File: rtl/mcd_clk_divsel_chk.sv
module mcd_clk_divsel_chk #(
   parameter int unsigned DIV_HI   = 8,
   parameter int unsigned SLOTS    = 32,
   parameter int unsigned HOLD_CYC = 1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic fsx_i,
   input logic filt_ce_o,
   input logic frame_ce_o,
   input logic sel_fast_o
);

   localparam int unsigned GMAX = DIV_HI + HOLD_CYC;
   localparam int unsigned GW   = $clog2(GMAX + 2);
   localparam int unsigned CW   = $clog2(SLOTS + 1);

   logic [GW-1:0] gap_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gap_q <= '0;
         cnt_q <= '0;
      end else begin
         if (filt_ce_o)                     gap_q <= '0;
         else if (gap_q != GW'(GMAX + 1))   gap_q <= gap_q + 1'b1;
         if (frame_ce_o)                    cnt_q <= '0;
         else if (filt_ce_o && cnt_q != CW'(SLOTS)) cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_FRAME_HAS_FILT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_ce_o |-> filt_ce_o); // R4

   AST_SLOTS_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (filt_ce_o && !frame_ce_o) |-> (cnt_q < CW'(SLOTS - 1))); // R4

   AST_FILT_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      filt_ce_o |=> (!filt_ce_o || frame_ce_o)); // R2

   AST_SEL_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sel_fast_o) |-> frame_ce_o); // R7

   AST_FSX_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fsx_i) |=> (frame_ce_o && filt_ce_o)); // R8

   AST_FILT_GAP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      filt_ce_o |-> (gap_q <= GW'(GMAX))); // R9

endmodule

bind mcd_clk_divsel mcd_clk_divsel_chk #(
   .DIV_HI   (DIV_HI),
   .SLOTS    (SLOTS),
   .HOLD_CYC (HOLD_CYC)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .fsx_i      (fsx_i),
   .filt_ce_o  (filt_ce_o),
   .frame_ce_o (frame_ce_o),
   .sel_fast_o (sel_fast_o)
);

// File: tb/mcd_clk_divsel_tb_top.sv
`timescale 1ns/1ps
module mcd_clk_divsel_tb_top;

   logic clk_i = 1'b0;
   logic rst_ni = 1'b0;
   logic bclkr_pin_i = 1'b1;
   logic fsx_i = 1'b0;
   logic filt_ce_o, frame_ce_o, sync_mode_o, sel_fast_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk_i = ~clk_i;

   mcd_clk_divsel dut_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bclkr_pin_i (bclkr_pin_i),
      .fsx_i       (fsx_i),
      .filt_ce_o   (filt_ce_o),
      .frame_ce_o  (frame_ce_o),
      .sync_mode_o (sync_mode_o),
      .sel_fast_o  (sel_fast_o)
   );

   // pulse statistics, collected at falling edges
   int cyc = 0;
   int last_filt = 0, last_frame = 0, prev_frame = 0, frame_gap_last = 0;
   int fcount = 0;
   int fmin, fmax, frmin, frmax, cmin, cmax;
   bit armed = 0, clear_req = 0;

   always @(negedge clk_i) begin
      cyc = cyc + 1;
      if (frame_ce_o && clear_req) begin
         clear_req = 0; armed = 1; fcount = 0;
         last_filt = cyc; last_frame = cyc;
         fmin = 1000000; fmax = 0; frmin = 1000000; frmax = 0;
         cmin = 1000000; cmax = 0;
      end else if (armed) begin
         if (filt_ce_o) begin
            if (cyc - last_filt < fmin) fmin = cyc - last_filt;
            if (cyc - last_filt > fmax) fmax = cyc - last_filt;
            last_filt = cyc;
            fcount = fcount + 1;
         end
         if (frame_ce_o) begin
            if (cyc - last_frame < frmin) frmin = cyc - last_frame;
            if (cyc - last_frame > frmax) frmax = cyc - last_frame;
            if (fcount < cmin) cmin = fcount;
            if (fcount > cmax) cmax = fcount;
            fcount = 0;
            last_frame = cyc;
         end
      end
      if (frame_ce_o) begin
         frame_gap_last = cyc - prev_frame;
         prev_frame = cyc;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk_i);
      #1;
   endtask

   task automatic wait_frames(input int n);
      repeat (n) begin
         do begin
            @(negedge clk_i); #1;
         end while (!frame_ce_o);
      end
   endtask

   // one-cycle sync pulses, rising edges spaced per clocks apart
   task automatic fsx_train(input int n, input int per);
      for (int k = 0; k < n; k++) begin
         fsx_i = 1'b1;
         @(negedge clk_i); #1;
         check(frame_ce_o == 1'b1, "R8 frame strobe after sync", frame_ce_o, 1);
         check(filt_ce_o == 1'b1, "R8 filter enable after sync", filt_ce_o, 1);
         fsx_i = 1'b0;
         repeat (per - 1) @(negedge clk_i);
         #1;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // reset state (R1)
      cycles(5);
      check(filt_ce_o == 0, "R1 filt_ce in reset", filt_ce_o, 0);
      check(frame_ce_o == 0, "R1 frame_ce in reset", frame_ce_o, 0);
      check(sync_mode_o == 0, "R1 sync_mode in reset", sync_mode_o, 0);
      check(sel_fast_o == 1, "R1 sel_fast in reset", sel_fast_o, 1);
      rst_ni = 1'b1;

      // static high pin, 2.048 MHz free run
      cycles(100);
      check(sync_mode_o == 1, "R5 static after hold", sync_mode_o, 1);
      clear_req = 1;
      wait_frames(4);
      check(fmin == 8 && fmax == 8, "R2 filter interval", fmax, 8);
      check(frmin == 256 && frmax == 256, "R2 frame interval", frmax, 256);
      check(cmin == 32 && cmax == 32, "R4 enables per frame", cmax, 32);

      // switch select to low
      bclkr_pin_i = 1'b0;
      cycles(5);
      check(sync_mode_o == 0, "R5 drop after edge", sync_mode_o, 0);
      cycles(25);
      check(sync_mode_o == 0, "R5 still low in window", sync_mode_o, 0);
      cycles(70);
      check(sync_mode_o == 1, "R5 static again", sync_mode_o, 1);
      begin
         int guard = 0;
         while (sel_fast_o && guard < 600) begin
            @(negedge clk_i); #1; guard++;
         end
      end
      check(sel_fast_o == 0, "R7 select applied", sel_fast_o, 0);
      check(frame_ce_o == 1, "R7 select change on frame strobe", frame_ce_o, 1);
      clear_req = 1;
      wait_frames(4);
      check(fmin == 6 && fmax == 6, "R3 filter interval", fmax, 6);
      check(frmin == 192 && frmax == 192, "R3 frame interval", frmax, 192);
      check(cmin == 32 && cmax == 32, "R4 enables per frame low rate", cmax, 32);

      // toggling pin: not a select
      for (int i = 0; i < 200; i++) begin
         bclkr_pin_i = ~bclkr_pin_i;
         cycles(3);
         if (i == 199) check(sync_mode_o == 0, "R5 clocking pin", sync_mode_o, 0);
      end
      check(sel_fast_o == 0, "R6 select kept while clocking", sel_fast_o, 0);
      cycles(300);
      check(sync_mode_o == 1, "R5 static after clocking", sync_mode_o, 1);
      check(sel_fast_o == 0, "R6 select after clocking", sel_fast_o, 0);

      // 193-clock frames
      clear_req = 1;
      fsx_train(5, 193);
      check(frmin == 193 && frmax == 193, "R9 locked frame length", frmax, 193);
      check(fmin == 6 && fmax == 7, "R9 filter interval with swallow", fmax, 7);
      check(cmin == 32 && cmax == 32, "R9 enables per locked frame", cmax, 32);

      // 192-clock frames, then loss of sync
      clear_req = 1;
      fsx_train(5, 192);
      check(frmin == 192 && frmax == 192, "R8 locked 192 frame", frmax, 192);
      check(fmax == 6, "R8 no swallow at 192", fmax, 6);
      wait_frames(1);
      check(frame_gap_last == 193, "R10 first frame without sync", frame_gap_last, 193);
      wait_frames(1);
      check(frame_gap_last == 192, "R10 nominal after lock loss", frame_gap_last, 192);
      wait_frames(1);
      check(frame_gap_last == 192, "R10 stays nominal", frame_gap_last, 192);

      // back to 2.048 MHz with a 256-clock sync
      bclkr_pin_i = 1'b1;
      cycles(600);
      check(sel_fast_o == 1, "R6 select high captured", sel_fast_o, 1);
      clear_req = 1;
      fsx_train(4, 256);
      check(frmin == 256 && frmax == 256, "R2 frame with sync", frmax, 256);
      check(fmin == 8 && fmax == 8, "R2 filter interval with sync", fmax, 8);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule